// File: doc/BRIEF.md
# ADC Command Register Sequencer

This block holds the command word that software uses to drive an analog-to-digital converter core. Software writes it to ask for calibration, power-up, shutdown, conversion start and conversion stop. Each of these command bits is a request level sent to the converter core. Software can set a command bit but cannot clear it. The bit stays high until the core returns the completion pulse for that operation. A separate regulator-enable bit is the only field that software can both set and clear.

Every write is checked against the command bits that are already set, and any illegal request is dropped without notice. Internally, the legal combinations of command bits form a six-state machine:

- `ST_OFF`: no command bit is set.
- `ST_CAL`: calibration is running.
- `ST_ON`: the converter is enabled and idle.
- `ST_RUN`: the converter is enabled and converting.
- `ST_HALT`: a stop command is pending while conversion is still flagged.
- `ST_SHUT`: a shutdown command is pending.

The transitions are:

- OFF→CAL: legal calibrate write.
- OFF→ON: legal enable write.
- CAL→OFF: calibration done.
- ON→SHUT: legal disable write.
- ON→RUN: legal start write.
- RUN→ON: automatic start clear, chosen by the conversion mode.
- RUN→HALT: legal stop write.
- HALT→ON: conversion discarded.
- SHUT→OFF: core powered down.

A separate flag records that the core has reported ready while the converter is enabled.

Top module: `adc_cmd_ctrl`

## Requirements
- R1: The command word uses these bits: enable at bit 0, disable at bit 1, start at bit 2, stop at bit 4, regulator enable at bit 28, calibrate at bit 31. Every other bit reads as 0, and after reset the whole word reads 0.
- R2: A write of 1 to calibrate is accepted only when all five command bits are 0. The bit clears on the cycle after the calibration-done pulse. If one write sets both calibrate and enable, only calibrate is taken.
- R3: A write of 1 to enable is accepted only when all five command bits are 0. The ready output rises after a ready pulse that arrives while enable is set, and it falls when shutdown completes.
- R4: A write of 1 to disable is accepted only while enable is 1 and start is 0. The shutdown-done pulse clears disable and enable together. If one write sets both disable and start, only disable is taken.
- R5: A write of 1 to start is accepted only while enable is 1, disable is 0 and the channel-configuration-ready input is 1.
- R6: In single mode (continuous 0, discontinuous 0, trigger select 00), start clears on an end-of-sequence pulse. In discontinuous mode (continuous 0, discontinuous 1, trigger select 00), start clears on an end-of-conversion pulse. In every other mode, start stays set until a stop completes.
- R7: A write of 1 to stop is accepted only while start is 1 and disable is 0. The discard-done pulse clears stop and start in the same cycle.
- R8: The regulator-enable bit follows the written value only while all five command bits are 0. Otherwise it keeps its value.
- R9: Writing 0 to a command bit has no effect. If a hardware clear and a legal write affect the same state in one cycle, the hardware clear wins and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Write strobe for the command word |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Current command word |
| mode_cont | input | 1 | Continuous conversion mode |
| mode_disc | input | 1 | Discontinuous conversion mode |
| trig_sel | input | 2 | Trigger edge select (00 = software trigger) |
| chan_cfg_ok | input | 1 | Channel configuration is settled |
| ev_cal_done | input | 1 | Pulse: calibration finished |
| ev_ready | input | 1 | Pulse: core is ready |
| ev_off_done | input | 1 | Pulse: core powered down |
| ev_stop_done | input | 1 | Pulse: ongoing conversion discarded |
| ev_eoc | input | 1 | Pulse: end of one conversion |
| ev_eos | input | 1 | Pulse: end of conversion sequence |
| req_cal | output | 1 | Calibration request level |
| req_en | output | 1 | Enable request level |
| req_dis | output | 1 | Disable request level |
| req_start | output | 1 | Start request level |
| req_stop | output | 1 | Stop request level |
| req_vreg | output | 1 | Regulator enable level |
| conv_ready | output | 1 | Core is enabled and has reported ready |

## Verification
Every command bit is decoded directly from the state register. A wrong state therefore shows on `reg_rdata` and on the request levels on the first clock after the write or pulse that caused it. It never stays hidden until some later command. A missing hardware clear shows as a stuck request level, and an accepted illegal write shows as an illegal bit combination. A wrong mode selection for the automatic start clear shows on `req_start` one cycle after the end-of-conversion or end-of-sequence pulse.

// File: rtl/adc_cmd_pkg.sv
package adc_cmd_pkg;
    localparam int WORD_W    = 32;
    localparam int TRIG_W    = 2;
    localparam int BIT_EN    = 0;
    localparam int BIT_DIS   = 1;
    localparam int BIT_START = 2;
    localparam int BIT_STOP  = 4;
    localparam int BIT_VREG  = 28;
    localparam int BIT_CAL   = 31;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_CAL,
        ST_ON,
        ST_RUN,
        ST_HALT,
        ST_SHUT
    } cmd_state_t;

    typedef struct packed {
        logic cal;
        logic en;
        logic dis;
        logic start;
        logic stop;
    } cmd_take_t;
endpackage

// File: rtl/adc_cmd_gate.sv
module adc_cmd_gate
    import adc_cmd_pkg::*;
#(
    parameter int W = WORD_W
) (
    input  cmd_state_t   state,
    input  logic         wr,
    input  logic [W-1:0] wdata,
    input  logic         chan_ok,
    output cmd_take_t    take,
    output logic         vreg_wr
);
    logic idle_all;
    assign idle_all = (state == ST_OFF);

    always_comb begin
        take       = '0;
        // Calibrate has priority over enable when both are written at once.
        take.cal   = wr && wdata[BIT_CAL] && idle_all;
        take.en    = wr && wdata[BIT_EN] && idle_all && !wdata[BIT_CAL];
        // Disable has priority over start when both are written at once.
        take.dis   = wr && wdata[BIT_DIS] && (state == ST_ON);
        take.start = wr && wdata[BIT_START] && (state == ST_ON) && chan_ok
                     && !wdata[BIT_DIS];
        take.stop  = wr && wdata[BIT_STOP] && (state == ST_RUN);
        vreg_wr    = wr && idle_all;
    end
endmodule

// File: rtl/adc_start_release.sv
module adc_start_release
    import adc_cmd_pkg::*;
#(
    parameter int TW = TRIG_W
) (
    input  logic          mode_cont,
    input  logic          mode_disc,
    input  logic [TW-1:0] trig_sel,
    input  logic          ev_eoc,
    input  logic          ev_eos,
    output logic          auto_clr
);
    logic sw_trig;
    assign sw_trig = (trig_sel == '0);

    always_comb begin
        auto_clr = 1'b0;
        if (sw_trig && !mode_cont) begin
            if (mode_disc) auto_clr = ev_eoc;
            else           auto_clr = ev_eos;
        end
    end
endmodule

// File: rtl/adc_ready_track.sv
module adc_ready_track (
    input  logic clk,
    input  logic rst_n,
    input  logic enabled,
    input  logic shut_done,
    input  logic ev_ready,
    output logic ready
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                   ready <= 1'b0;
        else if (shut_done)           ready <= 1'b0;
        else if (ev_ready && enabled) ready <= 1'b1;
    end
endmodule

// File: rtl/adc_cmd_ctrl.sv
module adc_cmd_ctrl
    import adc_cmd_pkg::*;
#(
    parameter int W  = WORD_W,
    parameter int TW = TRIG_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reg_wr,
    input  logic [W-1:0]  reg_wdata,
    output logic [W-1:0]  reg_rdata,
    input  logic          mode_cont,
    input  logic          mode_disc,
    input  logic [TW-1:0] trig_sel,
    input  logic          chan_cfg_ok,
    input  logic          ev_cal_done,
    input  logic          ev_ready,
    input  logic          ev_off_done,
    input  logic          ev_stop_done,
    input  logic          ev_eoc,
    input  logic          ev_eos,
    output logic          req_cal,
    output logic          req_en,
    output logic          req_dis,
    output logic          req_start,
    output logic          req_stop,
    output logic          req_vreg,
    output logic          conv_ready
);
    cmd_state_t state_q, state_d;
    cmd_take_t  take;
    logic       vreg_wr, vreg_q, auto_clr, shut_done;

    adc_cmd_gate #(.W(W)) u_gate (
        .state   (state_q),
        .wr      (reg_wr),
        .wdata   (reg_wdata),
        .chan_ok (chan_cfg_ok),
        .take    (take),
        .vreg_wr (vreg_wr)
    );

    adc_start_release #(.TW(TW)) u_rel (
        .mode_cont (mode_cont),
        .mode_disc (mode_disc),
        .trig_sel  (trig_sel),
        .ev_eoc    (ev_eoc),
        .ev_eos    (ev_eos),
        .auto_clr  (auto_clr)
    );

    assign shut_done = (state_q == ST_SHUT) && ev_off_done;

    adc_ready_track u_rdy (
        .clk       (clk),
        .rst_n     (rst_n),
        .enabled   (req_en),
        .shut_done (shut_done),
        .ev_ready  (ev_ready),
        .ready     (conv_ready)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_OFF;
        else        state_q <= state_d;
    end

    // Next state: hardware completions are tested first, so they win.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (take.cal)     state_d = ST_CAL;
                else if (take.en) state_d = ST_ON;
            end
            ST_CAL:  if (ev_cal_done) state_d = ST_OFF;
            ST_ON: begin
                if (take.dis)        state_d = ST_SHUT;
                else if (take.start) state_d = ST_RUN;
            end
            ST_RUN: begin
                if (auto_clr)       state_d = ST_ON;
                else if (take.stop) state_d = ST_HALT;
            end
            ST_HALT: if (ev_stop_done) state_d = ST_ON;
            ST_SHUT: if (ev_off_done)  state_d = ST_OFF;
            default: state_d = ST_OFF;
        endcase
    end

    // Request levels decoded from the state
    always_comb begin
        req_cal   = 1'b0;
        req_en    = 1'b0;
        req_dis   = 1'b0;
        req_start = 1'b0;
        req_stop  = 1'b0;
        unique case (state_q)
            ST_OFF:  ;
            ST_CAL:  req_cal = 1'b1;
            ST_ON:   req_en  = 1'b1;
            ST_RUN: begin
                req_en    = 1'b1;
                req_start = 1'b1;
            end
            ST_HALT: begin
                req_en    = 1'b1;
                req_start = 1'b1;
                req_stop  = 1'b1;
            end
            ST_SHUT: begin
                req_en  = 1'b1;
                req_dis = 1'b1;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       vreg_q <= 1'b0;
        else if (vreg_wr) vreg_q <= reg_wdata[BIT_VREG];
    end
    assign req_vreg = vreg_q;

    always_comb begin
        reg_rdata            = '0;
        reg_rdata[BIT_EN]    = req_en;
        reg_rdata[BIT_DIS]   = req_dis;
        reg_rdata[BIT_START] = req_start;
        reg_rdata[BIT_STOP]  = req_stop;
        reg_rdata[BIT_VREG]  = vreg_q;
        reg_rdata[BIT_CAL]   = req_cal;
    end

    AST_CAL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_cal && !ev_cal_done |=> req_cal); // R2
    AST_READY_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        conv_ready |-> req_en); // R3
    AST_SHUT_CLEARS_BOTH: assert property (@(posedge clk) disable iff (!rst_n)
        req_dis && ev_off_done |=> !req_en && !req_dis); // R4
    AST_START_NEEDS_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(req_start) |-> $past(chan_cfg_ok)); // R5
    AST_CONT_HOLDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_start && mode_cont && !ev_stop_done |=> req_start); // R6
    AST_STOP_CLEARS_START: assert property (@(posedge clk) disable iff (!rst_n)
        req_stop && ev_stop_done |=> !req_start && !req_stop); // R7
    AST_VREG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_OFF) |=> $stable(vreg_q)); // R8
endmodule

// File: tb/tb_adc_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_adc_cmd_ctrl;
    localparam logic [31:0] EN = 32'h0000_0001;
    localparam logic [31:0] DI = 32'h0000_0002;
    localparam logic [31:0] ST = 32'h0000_0004;
    localparam logic [31:0] SP = 32'h0000_0010;
    localparam logic [31:0] VR = 32'h1000_0000;
    localparam logic [31:0] CA = 32'h8000_0000;

    logic clk = 1'b0, rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic mode_cont = 1'b0, mode_disc = 1'b0;
    logic [1:0] trig_sel = 2'b00;
    logic chan_cfg_ok = 1'b1;
    logic ev_cal_done = 1'b0, ev_ready = 1'b0, ev_off_done = 1'b0;
    logic ev_stop_done = 1'b0, ev_eoc = 1'b0, ev_eos = 1'b0;
    logic req_cal, req_en, req_dis, req_start, req_stop, req_vreg, conv_ready;
    int n_chk = 0, n_fail = 0;

    always #2 clk = ~clk;

    adc_cmd_ctrl dut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .mode_cont(mode_cont), .mode_disc(mode_disc),
        .trig_sel(trig_sel), .chan_cfg_ok(chan_cfg_ok),
        .ev_cal_done(ev_cal_done), .ev_ready(ev_ready), .ev_off_done(ev_off_done),
        .ev_stop_done(ev_stop_done), .ev_eoc(ev_eoc), .ev_eos(ev_eos),
        .req_cal(req_cal), .req_en(req_en), .req_dis(req_dis),
        .req_start(req_start), .req_stop(req_stop), .req_vreg(req_vreg),
        .conv_ready(conv_ready)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [31:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0;
    endtask

    task automatic pulse(input int which);
        @(negedge clk);
        case (which)
            0: ev_cal_done = 1'b1;
            1: ev_ready = 1'b1;
            2: ev_off_done = 1'b1;
            3: ev_stop_done = 1'b1;
            4: ev_eoc = 1'b1;
            default: ev_eos = 1'b1;
        endcase
        @(negedge clk);
        {ev_cal_done, ev_ready, ev_off_done, ev_stop_done, ev_eoc, ev_eos} = '0;
    endtask

    task automatic t_reset;
        check("R1 reset word", reg_rdata, '0);
        check("R1 reset ready", {31'd0, conv_ready}, 0);
    endtask

    task automatic t_vreg;
        wr(VR);  check("R8 vreg set", reg_rdata, VR);
        check("R1 vreg pin", {31'd0, req_vreg}, 1);
        wr(0);   check("R8 vreg clear", reg_rdata, 0);
        wr(VR);  check("R8 vreg set again", reg_rdata, VR);
    endtask

    task automatic t_cal;
        wr(CA | EN | VR); check("R2 cal wins over enable", reg_rdata, VR | CA);
        wr(EN | VR);      check("R3 enable blocked while cal", reg_rdata, VR | CA);
        wr(0);            check("R8 vreg locked while cal", reg_rdata, VR | CA);
        pulse(0);         check("R2 cal cleared by done", reg_rdata, VR);
    endtask

    task automatic t_enable;
        wr(EN | VR);      check("R3 enable taken", reg_rdata, VR | EN);
        check("R3 not ready yet", {31'd0, conv_ready}, 0);
        wr(CA | VR);      check("R2 cal blocked while enabled", reg_rdata, VR | EN);
        pulse(1);         check("R3 ready after pulse", {31'd0, conv_ready}, 1);
        wr(SP | VR);      check("R7 stop blocked without start", reg_rdata, VR | EN);
        wr(0);            check("R9 zero write no effect", reg_rdata, VR | EN);
    endtask

    task automatic t_start_gate;
        chan_cfg_ok = 1'b0;
        wr(ST | VR);      check("R5 start blocked cfg not ready", reg_rdata, VR | EN);
        chan_cfg_ok = 1'b1;
        wr(ST | VR);      check("R5 start taken", reg_rdata, VR | EN | ST);
        wr(DI | VR);      check("R4 disable blocked while start", reg_rdata, VR | EN | ST);
    endtask

    task automatic t_modes;
        pulse(4);         check("R6 single ignores eoc", reg_rdata, VR | EN | ST);
        pulse(5);         check("R6 single clears on eos", reg_rdata, VR | EN);
        mode_disc = 1'b1;
        wr(ST | VR);
        pulse(4);         check("R6 disc clears on eoc", reg_rdata, VR | EN);
        mode_disc = 1'b0; mode_cont = 1'b1;
        wr(ST | VR);
        pulse(5); pulse(4);
        check("R6 cont holds start", reg_rdata, VR | EN | ST);
        wr(SP | VR);      check("R7 stop taken", reg_rdata, VR | EN | ST | SP);
        wr(0);            check("R9 zero write keeps stop", reg_rdata, VR | EN | ST | SP);
        pulse(3);         check("R7 stop done clears both", reg_rdata, VR | EN);
        mode_cont = 1'b0; trig_sel = 2'b01;
        wr(ST | VR);
        pulse(5);         check("R6 hw trigger holds start", reg_rdata, VR | EN | ST);
        wr(SP | VR); pulse(3);
        check("R7 stop done hw trigger", reg_rdata, VR | EN);
        trig_sel = 2'b00;
    endtask

    task automatic t_collision;
        wr(ST | VR);
        @(negedge clk);
        reg_wr = 1'b1; reg_wdata = SP | VR; ev_eos = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0; reg_wdata = '0; ev_eos = 1'b0;
        check("R9 hw clear wins over stop write", reg_rdata, VR | EN);
    endtask

    task automatic t_shutdown;
        wr(DI | ST | VR); check("R4 disable wins over start", reg_rdata, VR | EN | DI);
        wr(ST | VR);      check("R5 start blocked while disable", reg_rdata, VR | EN | DI);
        check("R3 ready held during disable", {31'd0, conv_ready}, 1);
        pulse(2);         check("R4 shutdown clears en and dis", reg_rdata, VR);
        check("R3 ready drops on shutdown", {31'd0, conv_ready}, 0);
        wr(0);            check("R8 vreg clear when idle", reg_rdata, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_vreg();
        t_cal();
        t_enable();
        t_start_gate();
        t_modes();
        t_collision();
        t_shutdown();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule